// File: doc/BRIEF.md
# Buffered Asynchronous Serial Receiver

This block is one receive channel of an asynchronous serial interface. It watches a serial line that rests at mark (high) and is gated by a sample enable that pulses sixteen times per bit period. When the line falls it times to the middle of the start bit and checks that the line is still low there. A start bit that has already returned high is thrown away. It then samples 5 to 8 data bits, least significant bit first, and after them an optional parity bit and the stop bit. Each finished character goes into a four-entry holding queue together with its parity-error, framing-error and break flags.

A long space on the line is reported as a line break. This also works when the space begins partway through a character: the interrupted character is stored with a framing error, and a separate break entry follows it. One-cycle pulses mark the start and the end of each break, and another pulse marks a character lost to overrun. An active-low request-to-send output can follow the queue occupancy, so that a remote transmitter is held off while all four entries are in use.

Top module: `srx_channel`

## Requirements
- R1: After reset, `ready`, `full`, `overrun`, `brk_start` and `brk_end` are low, and `rts_n` is low.
- R2: Data arrives least significant bit first. `cfg_len` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Bit positions above the selected length read as zero in `rd_data`.
- R3: The `cfg_parity` codes are: 0 none, 1 even, 2 odd, 3 parity bit always 0, 4 parity bit always 1. Codes 5 to 7 act as none. When the received parity bit differs from the expected one, the entry's `rd_perr` is set.
- R4: A low level on the line that is high again at the eighth sample tick after it was first seen produces no character.
- R5: A character whose stop bit is sampled low is stored with `rd_ferr` set.
- R6: The queue holds four entries. `ready` is high while at least one entry is held and `full` is high while four are held. `pop` removes the oldest entry, and `rd_*` always show the oldest entry. A `pop` on an empty queue changes nothing.
- R7: A character that completes while four entries are held is discarded, the held entries are left unchanged, and `overrun` pulses high for one cycle.
- R8: When the line stays low from the start bit through the stop sample, a single entry is stored with data 0, `rd_brk` set and both error flags clear, and `brk_start` pulses. Nothing further is stored until the line returns high, and at that point `brk_end` pulses.
- R9: When the line falls low in the middle of a character and stays low, the interrupted character is stored with `rd_ferr` set. A break entry as in R8 follows once the run of consecutive low samples equals the frame length (start, data, parity and stop bits).
- R10: With `flow_en` high, `rts_n` is high while the queue is full and low otherwise. With `flow_en` low, `rts_n` stays low.
- R11: All bit timing counts only cycles in which `tick16` is high. The start bit is checked on the eighth tick after the line is seen low, and every later sample comes sixteen ticks after the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial line, mark high |
| tick16 | input | 1 | Sample enable, sixteen pulses per bit |
| cfg_len | input | 2 | Data length code (5 to 8 bits) |
| cfg_parity | input | 3 | Parity mode code |
| flow_en | input | 1 | Enables automatic request-to-send |
| pop | input | 1 | Removes the oldest queue entry |
| rd_data | output | DATA_W (8) | Data of the oldest entry |
| rd_perr | output | 1 | Parity error of the oldest entry |
| rd_ferr | output | 1 | Framing error of the oldest entry |
| rd_brk | output | 1 | Oldest entry is a break |
| ready | output | 1 | At least one entry is held |
| full | output | 1 | All four entries are held |
| overrun | output | 1 | One-cycle pulse: a character was lost |
| rts_n | output | 1 | Active-low request to send |
| brk_start | output | 1 | One-cycle pulse: a break was detected |
| brk_end | output | 1 | One-cycle pulse: the line returned high after a break |

## Verification
The hardest case to reach from the ports is a break that begins in the middle of a character. A correct result needs the framing-error entry and the break entry, in that order, and the break must not be reported too early. The stimulus sends a valid start bit and four high data bits, then holds the line low well past one full frame before letting it return high. A clean break, a framing error on a non-zero character, and a fifth character that arrives while all four entries are held round out the boundary cases. One frame is also sent with the sample enable at half rate.

// File: rtl/srx_pkg.sv
package srx_pkg;
   localparam logic [2:0] PM_NONE = 3'd0;
   localparam logic [2:0] PM_EVEN = 3'd1;
   localparam logic [2:0] PM_ODD  = 3'd2;
   localparam logic [2:0] PM_ZERO = 3'd3;
   localparam logic [2:0] PM_ONE  = 3'd4;

   localparam int STAT_W = 3;  // perr, ferr, brk

   typedef enum logic [2:0] {
      S_HUNT, S_START, S_DATA, S_PAR, S_STOP, S_FILL, S_BRK
   } rx_state_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   if (STAGES < 1 || STAGES > 4) begin : g_bad_stages
      $error("srx_sync: STAGES must be 1..4");
   end

   logic [STAGES-1:0] chain;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) chain <= '1;
         else        chain <= din;
   end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) chain <= '1;
         else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/srx_frame.sv
module srx_frame
   import srx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OSR    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx,
   input  logic [1:0]        cfg_len,
   input  logic [2:0]        cfg_parity,
   output logic              push,
   output logic [DATA_W-1:0] push_data,
   output logic              push_perr,
   output logic              push_ferr,
   output logic              push_brk,
   output logic              brk_start,
   output logic              brk_end
);
   localparam int CNT_W = $clog2(OSR);
   localparam int IDX_W = $clog2(DATA_W);
   localparam int RUN_W = $clog2(DATA_W + 4);
   localparam int HALF  = OSR / 2;

   if (DATA_W < 5 || DATA_W > 8) begin : g_bad_width
      $error("srx_frame: DATA_W must be 5..8");
   end
   if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
      $error("srx_frame: OSR must be even and at least 4");
   end

   rx_state_t         state;
   logic [CNT_W-1:0]  cnt;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] shreg;
   logic [RUN_W-1:0]  run, run_nx, nbits, fbits;
   logic              par_bit, par_on, par_exp, perr, at_half, at_full;

   always_comb begin
      nbits = RUN_W'(5) + RUN_W'(cfg_len);
      if (nbits > RUN_W'(DATA_W)) nbits = RUN_W'(DATA_W);
      par_on = (cfg_parity >= PM_EVEN) && (cfg_parity <= PM_ONE);
      unique case (cfg_parity)
         PM_EVEN: par_exp = ^shreg;
         PM_ODD:  par_exp = ~^shreg;
         PM_ONE:  par_exp = 1'b1;
         default: par_exp = 1'b0;
      endcase
      perr    = par_on && (par_bit != par_exp);
      fbits   = nbits + RUN_W'(2) + RUN_W'(par_on);
      at_half = tick && (cnt == CNT_W'(HALF - 1));
      at_full = tick && (cnt == CNT_W'(OSR - 1));
      run_nx  = rx ? '0 : run + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_HUNT;
         cnt       <= '0;
         idx       <= '0;
         shreg     <= '0;
         run       <= '0;
         par_bit   <= 1'b0;
         push      <= 1'b0;
         push_data <= '0;
         push_perr <= 1'b0;
         push_ferr <= 1'b0;
         push_brk  <= 1'b0;
         brk_start <= 1'b0;
         brk_end   <= 1'b0;
      end else begin
         push      <= 1'b0;
         brk_start <= 1'b0;
         brk_end   <= 1'b0;
         unique case (state)
            S_HUNT:
               if (tick && !rx) begin
                  state <= S_START;
                  cnt   <= '0;
               end
            S_START:
               if (at_half) begin
                  if (rx) state <= S_HUNT;
                  else begin
                     state <= S_DATA;
                     cnt   <= '0;
                     idx   <= '0;
                     shreg <= '0;
                     run   <= RUN_W'(1);
                  end
               end else if (tick) cnt <= cnt + 1'b1;
            S_DATA:
               if (at_full) begin
                  cnt        <= '0;
                  shreg[idx] <= rx;
                  run        <= run_nx;
                  if (RUN_W'(idx) == nbits - 1'b1) state <= par_on ? S_PAR : S_STOP;
                  else                             idx   <= idx + 1'b1;
               end else if (tick) cnt <= cnt + 1'b1;
            S_PAR:
               if (at_full) begin
                  cnt     <= '0;
                  par_bit <= rx;
                  run     <= run_nx;
                  state   <= S_STOP;
               end else if (tick) cnt <= cnt + 1'b1;
            S_STOP:
               if (at_full) begin
                  cnt  <= '0;
                  push <= 1'b1;
                  if (!rx && run_nx == fbits) begin
                     push_data <= '0;
                     push_perr <= 1'b0;
                     push_ferr <= 1'b0;
                     push_brk  <= 1'b1;
                     brk_start <= 1'b1;
                     state     <= S_BRK;
                  end else begin
                     push_data <= shreg;
                     push_perr <= perr;
                     push_ferr <= !rx;
                     push_brk  <= 1'b0;
                     run       <= run_nx;
                     state     <= rx ? S_HUNT : S_FILL;
                  end
               end else if (tick) cnt <= cnt + 1'b1;
            S_FILL:
               if (at_full) begin
                  cnt <= '0;
                  if (rx) state <= S_HUNT;
                  else if (run_nx == fbits) begin
                     push      <= 1'b1;
                     push_data <= '0;
                     push_perr <= 1'b0;
                     push_ferr <= 1'b0;
                     push_brk  <= 1'b1;
                     brk_start <= 1'b1;
                     state     <= S_BRK;
                  end else run <= run_nx;
               end else if (tick) cnt <= cnt + 1'b1;
            S_BRK:
               if (tick && rx) begin
                  brk_end <= 1'b1;
                  state   <= S_HUNT;
               end
            default: state <= S_HUNT;
         endcase
      end
   end
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         rd,
   output logic [W-1:0] rdata,
   output logic         nonempty,
   output logic         full,
   output logic         drop
);
   localparam int  AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int  CW   = $clog2(DEPTH + 1);
   localparam bit  POW2 = (DEPTH == (1 << AW));

   if (DEPTH < 2 || DEPTH > 64) begin : g_bad_depth
      $error("srx_fifo: DEPTH must be 2..64");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_nx, rp_nx;
   logic [CW-1:0] count;
   logic          do_wr, do_rd;

   if (POW2) begin : g_wrap
      assign wp_nx = wp + 1'b1;
      assign rp_nx = rp + 1'b1;
   end else begin : g_cmp
      assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
   end

   assign full     = (count == CW'(DEPTH));
   assign nonempty = (count != '0);
   assign do_wr    = wr && !full;
   assign do_rd    = rd && nonempty;
   assign rdata    = mem[rp];

   always_ff @(posedge clk)
      if (do_wr) mem[wp] <= wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
         drop  <= 1'b0;
      end else begin
         drop <= wr && full;
         if (do_wr) wp <= wp_nx;
         if (do_rd) rp <= rp_nx;
         unique case ({do_wr, do_rd})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/srx_channel.sv
module srx_channel
   import srx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int DEPTH       = 4,
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_line,
   input  logic              tick16,
   input  logic [1:0]        cfg_len,
   input  logic [2:0]        cfg_parity,
   input  logic              flow_en,
   input  logic              pop,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_perr,
   output logic              rd_ferr,
   output logic              rd_brk,
   output logic              ready,
   output logic              full,
   output logic              overrun,
   output logic              rts_n,
   output logic              brk_start,
   output logic              brk_end
);
   localparam int ENT_W = DATA_W + STAT_W;

   logic              rx_s, push, p_perr, p_ferr, p_brk;
   logic [DATA_W-1:0] p_data;
   logic [ENT_W-1:0]  head;

   srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(rx_s)
   );

   srx_frame #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
      .clk(clk), .rst_n(rst_n), .tick(tick16), .rx(rx_s),
      .cfg_len(cfg_len), .cfg_parity(cfg_parity),
      .push(push), .push_data(p_data), .push_perr(p_perr),
      .push_ferr(p_ferr), .push_brk(p_brk),
      .brk_start(brk_start), .brk_end(brk_end)
   );

   srx_fifo #(.DEPTH(DEPTH), .W(ENT_W)) u_fifo (
      .clk(clk), .rst_n(rst_n), .wr(push),
      .wdata({p_brk, p_ferr, p_perr, p_data}),
      .rd(pop), .rdata(head), .nonempty(ready), .full(full), .drop(overrun)
   );

   assign {rd_brk, rd_ferr, rd_perr, rd_data} = head;
   assign rts_n = flow_en & full;
endmodule

// File: rtl/srx_channel_chk.sv
module srx_channel_chk (
   input logic clk,
   input logic rst_n,
   input logic pop,
   input logic flow_en,
   input logic ready,
   input logic full,
   input logic overrun,
   input logic rts_n,
   input logic brk_start,
   input logic brk_end
);
   a_r6_full_has_entry: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> ready);

   a_r6_full_kept_without_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !pop) |=> full);

   a_r7_overrun_after_full: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> $past(full));

   a_r8_break_edges_apart: assert property (@(posedge clk) disable iff (!rst_n)
      !(brk_start && brk_end));

   a_r10_rts_back_on_space: assert property (@(posedge clk) disable iff (!rst_n)
      (flow_en && $fell(full)) |-> !rts_n);
endmodule

bind srx_channel srx_channel_chk u_chk (
   .clk(clk), .rst_n(rst_n), .pop(pop), .flow_en(flow_en), .ready(ready),
   .full(full), .overrun(overrun), .rts_n(rts_n),
   .brk_start(brk_start), .brk_end(brk_end)
);

// File: tb/tb_srx_channel.sv
module tb_srx_channel;
   localparam int CLK_P = 10;

   logic       clk = 0, rst_n = 0, rx_line = 1, tick16 = 0, flow_en = 0, pop = 0;
   logic [1:0] cfg_len = 2'd3;
   logic [2:0] cfg_parity = 3'd0;
   logic [7:0] rd_data;
   logic       rd_perr, rd_ferr, rd_brk, ready, full, overrun, rts_n, brk_start, brk_end;

   srx_channel dut (
      .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick16(tick16),
      .cfg_len(cfg_len), .cfg_parity(cfg_parity), .flow_en(flow_en), .pop(pop),
      .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
      .ready(ready), .full(full), .overrun(overrun), .rts_n(rts_n),
      .brk_start(brk_start), .brk_end(brk_end)
   );

   always #(CLK_P/2) clk = ~clk;

   typedef struct {
      logic [7:0] d;
      logic       pe, fe, bk;
   } ent_t;

   ent_t q[$];
   int   checks = 0, fails = 0;
   int   n_ovr = 0, n_bs = 0, n_be = 0, exp_ovr = 0, exp_bs = 0, exp_be = 0;
   int   tdiv = 1, tph = 0;
   bit   settled = 0, done = 0;

   always @(negedge clk) begin
      tph = (tph + 1) % tdiv;
      tick16 <= (tph == 0);
   end

   task automatic chk(input string req, input bit ok, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Per-clock comparison against the queue model while the line is quiet.
   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         if (overrun)   n_ovr++;
         if (brk_start) n_bs++;
         if (brk_end)   n_be++;
      end
      if (rst_n && settled) begin
         chk("R6 ready", ready == (q.size() > 0), ready, q.size() > 0);
         chk("R6 full", full == (q.size() == 4), full, q.size() == 4);
         chk("R10 rts_n", rts_n == (flow_en && q.size() == 4), rts_n, flow_en && q.size() == 4);
         if (q.size() > 0) begin
            chk("R2 head data", rd_data == q[0].d, rd_data, q[0].d);
            chk("R3 head perr", rd_perr == q[0].pe, rd_perr, q[0].pe);
            chk("R5 head ferr", rd_ferr == q[0].fe, rd_ferr, q[0].fe);
            chk("R8 head brk", rd_brk == q[0].bk, rd_brk, q[0].bk);
         end
      end
   end

   task automatic model_push(input ent_t e);
      if (q.size() < 4) q.push_back(e);
      else exp_ovr++;
   endtask

   task automatic send_char(input logic [7:0] d, input int len, input logic [2:0] pm,
                            input bit badp, input bit stopv);
      logic [15:0] fr;
      int          n;
      logic [7:0]  dm;
      logic        pb;
      ent_t        e;
      dm = d & 8'((1 << len) - 1);
      cfg_len = 2'(len - 5);
      cfg_parity = pm;
      fr = '0;
      fr[0] = 1'b0;
      for (int i = 0; i < len; i++) fr[1+i] = dm[i];
      n = 1 + len;
      if (pm >= 3'd1 && pm <= 3'd4) begin
         case (pm)
            3'd1:    pb = ^dm;
            3'd2:    pb = ~^dm;
            3'd4:    pb = 1'b1;
            default: pb = 1'b0;
         endcase
         fr[n] = pb ^ badp;
         n++;
      end
      fr[n] = stopv;
      n++;
      settled = 0;
      @(negedge clk);
      for (int i = 0; i < n; i++) begin
         rx_line = fr[i];
         repeat (16 * tdiv) @(negedge clk);
      end
      rx_line = 1'b1;
      repeat (40 * tdiv) @(negedge clk);
      e.d = dm; e.pe = badp; e.fe = !stopv; e.bk = 1'b0;
      model_push(e);
      settled = 1;
   endtask

   task automatic do_pop();
      @(negedge clk);
      pop = 1'b1;
      @(posedge clk);
      #1;
      if (q.size() > 0) void'(q.pop_front());
      @(negedge clk);
      pop = 1'b0;
   endtask

   task automatic chk_events(input string req);
      chk({req, " overrun count"}, n_ovr == exp_ovr, n_ovr, exp_ovr);
      chk({req, " break start count"}, n_bs == exp_bs, n_bs, exp_bs);
      chk({req, " break end count"}, n_be == exp_be, n_be, exp_be);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         summary();
         $finish;
      end
   end

   initial begin
      ent_t e;
      repeat (5) @(negedge clk);
      rst_n = 1;
      @(posedge clk);
      #2;
      // R1 reset state
      chk("R1 ready", ready == 0, ready, 0);
      chk("R1 full", full == 0, full, 0);
      chk("R1 rts_n", rts_n == 0, rts_n, 0);
      chk("R1 pulses", {overrun, brk_start, brk_end} == 3'b000, {overrun, brk_start, brk_end}, 0);
      settled = 1;

      // R2 eight data bits, no parity
      send_char(8'hA5, 8, 3'd0, 0, 1); do_pop();
      // R2 R3 five bits odd, seven bits even good and bad
      send_char(8'h15, 5, 3'd2, 0, 1); do_pop();
      send_char(8'hBC, 7, 3'd1, 0, 1); do_pop();
      send_char(8'h3C, 7, 3'd1, 1, 1);
      chk("R3 perr flagged", rd_perr == 1, rd_perr, 1);
      do_pop();
      // R3 forced parity values
      send_char(8'h2A, 6, 3'd4, 1, 1); do_pop();
      send_char(8'h13, 6, 3'd3, 0, 1); do_pop();
      // R5 framing error on non-zero character
      send_char(8'h81, 8, 3'd0, 0, 0);
      chk("R5 ferr flagged", rd_ferr == 1, rd_ferr, 1);
      do_pop();

      // R4 false start: short low glitch
      @(negedge clk);
      rx_line = 0;
      repeat (4) @(negedge clk);
      rx_line = 1;
      repeat (60) @(negedge clk);
      chk("R4 no character", ready == 0, ready, 0);

      // R11 half-rate sample enable
      tdiv = 2;
      send_char(8'h5A, 8, 3'd0, 0, 1);
      chk("R11 half rate data", rd_data == 8'h5A, rd_data, 8'h5A);
      do_pop();
      tdiv = 1;
      repeat (4) @(negedge clk);

      // R6 pop on empty queue
      do_pop();
      repeat (2) @(negedge clk);
      chk("R6 empty pop", ready == 0 && full == 0, ready, 0);

      // R10 R7 flow control and overrun
      flow_en = 1;
      send_char(8'h11, 8, 3'd0, 0, 1);
      send_char(8'h22, 8, 3'd0, 0, 1);
      send_char(8'h33, 8, 3'd0, 0, 1);
      send_char(8'h44, 8, 3'd0, 0, 1);
      chk("R10 rts_n high when full", rts_n == 1, rts_n, 1);
      send_char(8'h55, 8, 3'd0, 0, 1);
      chk("R7 oldest kept", rd_data == 8'h11, rd_data, 8'h11);
      chk_events("R7");
      do_pop();
      chk("R10 rts_n low after pop", rts_n == 0, rts_n, 0);
      do_pop(); do_pop();
      chk("R7 last held entry", rd_data == 8'h44, rd_data, 8'h44);
      do_pop();

      // R8 clean break
      settled = 0;
      @(negedge clk);
      rx_line = 0;
      repeat (250) @(negedge clk);
      rx_line = 1;
      repeat (40) @(negedge clk);
      e.d = 8'h00; e.pe = 0; e.fe = 0; e.bk = 1;
      model_push(e);
      exp_bs++; exp_be++;
      settled = 1;
      @(negedge clk);
      chk("R8 single break entry", rd_brk == 1 && rd_data == 0, rd_data, 0);
      chk_events("R8");
      do_pop();
      @(negedge clk);
      chk("R8 nothing after break", ready == 0, ready, 0);

      // R9 break starting inside a character
      settled = 0;
      cfg_len = 2'd3; cfg_parity = 3'd0;
      @(negedge clk);
      rx_line = 0;
      repeat (16) @(negedge clk);
      for (int i = 0; i < 4; i++) begin
         rx_line = 1;
         repeat (16) @(negedge clk);
      end
      rx_line = 0;
      repeat (300) @(negedge clk);
      rx_line = 1;
      repeat (40) @(negedge clk);
      e.d = 8'h0F; e.pe = 0; e.fe = 1; e.bk = 0;
      model_push(e);
      e.d = 8'h00; e.pe = 0; e.fe = 0; e.bk = 1;
      model_push(e);
      exp_bs++; exp_be++;
      settled = 1;
      @(negedge clk);
      chk("R9 interrupted char ferr", rd_ferr == 1 && rd_data == 8'h0F, rd_data, 8'h0F);
      chk_events("R9");
      do_pop();
      chk("R9 break entry follows", rd_brk == 1, rd_brk, 1);
      do_pop();

      flow_en = 0;
      repeat (3) @(negedge clk);
      chk("R10 rts_n with flow off", rts_n == 0, rts_n, 0);

      done = 1;
      summary();
      $finish;
   end
endmodule